// File: doc/BRIEF.md
# Microprogram Memory Segment Loader

This block is the maintenance-side controller for a set of wide microprogram stores. Each store holds 1024 words of 80 bits. Software reaches a word as five 16-bit segments, through an address/segment pointer that advances by itself. The controller keeps one pointer for each store and drives a shared 16-bit write path. It also captures a 16-bit read path into a dump register. One store at a time is enabled through a one-hot select.

Four operations are accepted. The first puts the pointer of the chosen store back to word zero, upper segment. The second lets the pointer free-run one position per clock until its word address equals a target taken from the host data input. The third writes the host data to the segment under the pointer. The fourth reads that segment into the dump register. A segment access always moves the pointer on by one segment. Commands are taken only while the processors report that they are stopped. While an operation runs, the block shows a busy flag, and it gives a one-cycle done pulse when the operation ends.

Top module: `mpm_seg_loader`

## Requirements
- R1: After reset, busy, done, memWe and memSel are all low, and every pointer rests at word 0, segment index 4. The output memAddr reads 0 and memSeg reads 4.
- R2: The pointer-reset operation (cmdOp = 0) sets the pointer of the selected store to word 0, segment 4. The pointers of the other stores keep their values.
- R3: Segment index 4 is the most significant segment, and the pointer counts down 4, 3, 2, 1, 0. A step from segment 0 goes to segment 4 of the next word. A step from word 1023, segment 0 wraps to word 0, segment 4.
- R4: The load operation (cmdOp = 2) raises memWe for exactly one clock. During that clock, memWrData is the host data latched when the command was taken, and the pointer shows the target segment. The pointer then advances one segment.
- R5: The dump operation (cmdOp = 3) captures memRdData at the current segment into dumpData and advances the pointer one segment. dumpData holds its value until the next dump.
- R6: The run operation (cmdOp = 1) advances the pointer once per clock while its word address differs from hostData[9:0]. Bits 15..10 of hostData take no part in the compare. When the compare hits, the segment is set back to 4 at the matched word and the operation ends. This includes the case where the pointer already sits on the target word.
- R7: While busy, memSel is one-hot with bit cmdMem set. While idle, memSel is zero. A command with cmdMem of 6 or more is ignored.
- R8: busy is high from the cycle after a command is taken through the last execute cycle. done is high for exactly one cycle, the cycle in which busy falls.
- R9: A command presented while busy, or while procStopped is low, is ignored. It starts no operation and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 0 pointer reset, 1 run to address, 2 segment load, 3 segment dump |
| cmdMem | input | 3 | Index of the target store |
| procStopped | input | 1 | High when the processors are halted |
| hostData | input | 16 | Low half of the host input register: target address or load data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| memSel | output | 6 | One-hot store enable |
| memAddr | output | 10 | Word address of the selected pointer |
| memSeg | output | 3 | Segment index of the selected pointer |
| memWe | output | 1 | One-clock write enable |
| memWrData | output | 16 | Segment write data |
| memRdData | input | 16 | Segment read data from the selected store |
| dumpData | output | 16 | Last dumped segment |

## Verification
A pointer that has drifted does not show at once. It shows on the next dump, which returns the wrong segment's value. After a run, it shows in the number of busy cycles, which follows exactly from the start position and the target. A wrong select or a stray write stays hidden until the affected location is dumped, so each write is followed by dumps that read the location back and that visit a neighbouring store. Wrap and realignment errors are caught by running to the last word, dumping across the wrap, and starting a run on the target word itself.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

  typedef enum logic [1:0] {
    OP_PTR_RESET = 2'd0,
    OP_RUN_TO    = 2'd1,
    OP_SEG_LOAD  = 2'd2,
    OP_SEG_DUMP  = 2'd3
  } mpm_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCmd;
    logic ptrClear;
    logic ptrStep;
    logic ptrRealign;
    logic rdCapture;
  } mpm_strobe_t;

endpackage

// File: rtl/mpm_ptr_cnt.sv
module mpm_ptr_cnt #(
  parameter int WORDS  = 1024,
  parameter int SEGS   = 5,
  parameter int ADDR_W = 10,
  parameter int SEG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              step,
  input  logic              realign,
  output logic [ADDR_W-1:0] addr,
  output logic [SEG_W-1:0]  seg
);
  localparam logic [SEG_W-1:0]  SEG_TOP   = SEG_W'(SEGS - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr <= '0;
      seg  <= SEG_TOP;
    end else if (clr) begin
      addr <= '0;
      seg  <= SEG_TOP;
    end else if (realign) begin
      seg <= SEG_TOP;
    end else if (step) begin
      if (seg == '0) begin
        seg  <= SEG_TOP;
        addr <= (addr == ADDR_LAST) ? '0 : addr + 1'b1;
      end else begin
        seg <= seg - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpm_ctrl.sv
module mpm_ctrl
  import mpm_pkg::*;
#(
  parameter int NUM_MEM = 6,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdOp,
  input  logic [SEL_W-1:0]   cmdMem,
  input  logic               procStopped,
  input  logic               addrHit,
  output logic               busy,
  output logic               done,
  output logic               writeEn,
  output logic [SEL_W-1:0]   selIdx,
  output logic [NUM_MEM-1:0] memSel,
  output mpm_strobe_t        strobe
);
  localparam logic [SEL_W:0] MEM_LIMIT = (SEL_W + 1)'(NUM_MEM);

  typedef enum logic {ST_IDLE, ST_EXEC} st_e;

  st_e              stQ;
  mpm_op_e          opQ;
  logic [SEL_W-1:0] selQ;
  logic             doneQ;
  logic             accept;
  logic             finish;

  assign accept = (stQ == ST_IDLE) && cmdValid && procStopped &&
                  ({1'b0, cmdMem} < MEM_LIMIT);
  assign finish = (stQ == ST_EXEC) && ((opQ != OP_RUN_TO) || addrHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      opQ   <= OP_PTR_RESET;
      selQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= finish;
      if (accept) begin
        stQ  <= ST_EXEC;
        opQ  <= mpm_op_e'(cmdOp);
        selQ <= cmdMem;
      end else if (finish) begin
        stQ <= ST_IDLE;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.latchCmd = accept;
    writeEn         = 1'b0;
    if (stQ == ST_EXEC) begin
      unique case (opQ)
        OP_PTR_RESET: strobe.ptrClear = 1'b1;
        OP_RUN_TO: begin
          strobe.ptrRealign = addrHit;
          strobe.ptrStep    = !addrHit;
        end
        OP_SEG_LOAD: begin
          writeEn        = 1'b1;
          strobe.ptrStep = 1'b1;
        end
        OP_SEG_DUMP: begin
          strobe.rdCapture = 1'b1;
          strobe.ptrStep   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_MEM; i++) begin
      memSel[i] = (stQ == ST_EXEC) && (selQ == SEL_W'(i));
    end
  end

  assign busy   = (stQ == ST_EXEC);
  assign done   = doneQ;
  assign selIdx = selQ;
endmodule

// File: rtl/mpm_dp.sv
module mpm_dp
  import mpm_pkg::*;
#(
  parameter int NUM_MEM = 6,
  parameter int WORDS   = 1024,
  parameter int SEGS    = 5,
  parameter int DATA_W  = 16,
  parameter int SEL_W   = 3,
  parameter int ADDR_W  = 10,
  parameter int SEG_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  mpm_strobe_t       strobe,
  input  logic [SEL_W-1:0]  selIdx,
  input  logic [DATA_W-1:0] hostLow,
  input  logic [DATA_W-1:0] memRdData,
  output logic              addrHit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [SEG_W-1:0]  memSeg,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] dumpData
);
  logic [ADDR_W-1:0] addrArr [NUM_MEM];
  logic [SEG_W-1:0]  segArr  [NUM_MEM];
  logic [ADDR_W-1:0] targetQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] dumpQ;

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_ptr
    logic own;
    assign own = (selIdx == SEL_W'(g));
    mpm_ptr_cnt #(
      .WORDS (WORDS),
      .SEGS  (SEGS),
      .ADDR_W(ADDR_W),
      .SEG_W (SEG_W)
    ) u_cnt (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (strobe.ptrClear && own),
      .step   (strobe.ptrStep && own),
      .realign(strobe.ptrRealign && own),
      .addr   (addrArr[g]),
      .seg    (segArr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetQ <= '0;
      wrDataQ <= '0;
      dumpQ   <= '0;
    end else begin
      if (strobe.latchCmd) begin
        targetQ <= hostLow[ADDR_W-1:0];
        wrDataQ <= hostLow;
      end
      if (strobe.rdCapture) begin
        dumpQ <= memRdData;
      end
    end
  end

  assign memAddr   = addrArr[selIdx];
  assign memSeg    = segArr[selIdx];
  assign addrHit   = (memAddr == targetQ);
  assign memWrData = wrDataQ;
  assign dumpData  = dumpQ;
endmodule

// File: rtl/mpm_seg_loader.sv
module mpm_seg_loader
  import mpm_pkg::*;
#(
  parameter int NUM_MEM = 6,
  parameter int WORDS   = 1024,
  parameter int SEGS    = 5,
  parameter int DATA_W  = 16,
  localparam int SEL_W  = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int SEG_W  = (SEGS > 1) ? $clog2(SEGS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdOp,
  input  logic [SEL_W-1:0]   cmdMem,
  input  logic               procStopped,
  input  logic [DATA_W-1:0]  hostData,
  output logic               busy,
  output logic               done,
  output logic [NUM_MEM-1:0] memSel,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [SEG_W-1:0]   memSeg,
  output logic               memWe,
  output logic [DATA_W-1:0]  memWrData,
  input  logic [DATA_W-1:0]  memRdData,
  output logic [DATA_W-1:0]  dumpData
);
  mpm_strobe_t      strobe;
  logic [SEL_W-1:0] selIdx;
  logic             addrHit;

  mpm_ctrl #(
    .NUM_MEM(NUM_MEM),
    .SEL_W  (SEL_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdMem     (cmdMem),
    .procStopped(procStopped),
    .addrHit    (addrHit),
    .busy       (busy),
    .done       (done),
    .writeEn    (memWe),
    .selIdx     (selIdx),
    .memSel     (memSel),
    .strobe     (strobe)
  );

  mpm_dp #(
    .NUM_MEM(NUM_MEM),
    .WORDS  (WORDS),
    .SEGS   (SEGS),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W),
    .SEG_W  (SEG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .selIdx   (selIdx),
    .hostLow  (hostData),
    .memRdData(memRdData),
    .addrHit  (addrHit),
    .memAddr  (memAddr),
    .memSeg   (memSeg),
    .memWrData(memWrData),
    .dumpData (dumpData)
  );
endmodule

// File: rtl/mpm_seg_loader_chk.sv
module mpm_seg_loader_chk #(
  parameter int NUM_MEM = 6,
  parameter int WORDS   = 1024,
  parameter int SEGS    = 5,
  parameter int ADDR_W  = 10,
  parameter int SEG_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               procStopped,
  input logic               busy,
  input logic               done,
  input logic [NUM_MEM-1:0] memSel,
  input logic [ADDR_W-1:0]  memAddr,
  input logic [SEG_W-1:0]   memSeg,
  input logic               memWe
);
  localparam logic [SEG_W-1:0]  SEG_TOP   = SEG_W'(SEGS - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(WORDS - 1);

  a_r4_we_single: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  a_r4_we_one_store: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($countones(memSel) == 1));

  a_r4_step_after_write: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (($past(memSeg) != '0 && memSeg == $past(memSeg) - 1'b1 &&
                memAddr == $past(memAddr)) ||
               ($past(memSeg) == '0 && memSeg == SEG_TOP &&
                memAddr == (($past(memAddr) == ADDR_LAST) ? '0 : $past(memAddr) + 1'b1))));

  a_r3_seg_range: assert property (@(posedge clk) disable iff (!rstN)
    memSeg <= SEG_TOP);

  a_r7_idle_no_sel: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memSel == '0));

  a_r7_busy_one_sel: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(memSel) == 1));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  a_r9_running_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !procStopped) |=> !busy);
endmodule

bind mpm_seg_loader mpm_seg_loader_chk #(
  .NUM_MEM(NUM_MEM),
  .WORDS  (WORDS),
  .SEGS   (SEGS),
  .ADDR_W (ADDR_W),
  .SEG_W  (SEG_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .procStopped(procStopped),
  .busy       (busy),
  .done       (done),
  .memSel     (memSel),
  .memAddr    (memAddr),
  .memSeg     (memSeg),
  .memWe      (memWe)
);

// File: tb/sim_mpm_seg_loader.sv
module sim_mpm_seg_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [2:0]  cmdMem = 3'd0;
  logic        procStopped = 1'b1;
  logic [15:0] hostData = 16'h0;
  logic        busy, done, memWe;
  logic [5:0]  memSel;
  logic [9:0]  memAddr;
  logic [2:0]  memSeg;
  logic [15:0] memWrData, memRdData, dumpData;

  int total = 0;
  int bad = 0;
  int weCount = 0;
  int busyCyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mpm_seg_loader u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdMem(cmdMem),
    .procStopped(procStopped), .hostData(hostData), .busy(busy), .done(done),
    .memSel(memSel), .memAddr(memAddr), .memSeg(memSeg), .memWe(memWe),
    .memWrData(memWrData), .memRdData(memRdData), .dumpData(dumpData)
  );

  function automatic logic [15:0] initVal(int m, int a, int s);
    return 16'((m * 4099 + a * 7 + s * 1031) ^ 16'h3C5A);
  endfunction

  // store model: six stores of 1024 words x 5 segments
  logic [15:0] store [6][1024][5];

  initial begin
    for (int m = 0; m < 6; m++)
      for (int a = 0; a < 1024; a++)
        for (int s = 0; s < 5; s++)
          store[m][a][s] = initVal(m, a, s);
  end

  always_comb begin
    memRdData = 16'h0;
    for (int m = 0; m < 6; m++)
      if (memSel[m]) memRdData = store[m][memAddr][memSeg];
  end

  always @(posedge clk) begin
    if (memWe) begin
      weCount <= weCount + 1;
      for (int m = 0; m < 6; m++)
        if (memSel[m]) store[m][memAddr][memSeg] <= memWrData;
    end
  end

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  mem;
    logic [15:0] data;
    logic        chk;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd2, 16'h0000, 1'b0, 16'h0000},
    '{2'd2, 3'd2, 16'hA111, 1'b0, 16'h0000},
    '{2'd2, 3'd2, 16'hB222, 1'b0, 16'h0000},
    '{2'd0, 3'd2, 16'h0000, 1'b0, 16'h0000},
    '{2'd3, 3'd2, 16'h0000, 1'b1, 16'hA111},
    '{2'd3, 3'd2, 16'h0000, 1'b1, 16'hB222},
    '{2'd3, 3'd2, 16'h0000, 1'b1, initVal(2, 0, 2)},
    '{2'd3, 3'd2, 16'h0000, 1'b1, initVal(2, 0, 1)},
    '{2'd3, 3'd2, 16'h0000, 1'b1, initVal(2, 0, 0)},
    '{2'd3, 3'd2, 16'h0000, 1'b1, initVal(2, 1, 4)},
    '{2'd3, 3'd5, 16'h0000, 1'b1, initVal(5, 0, 4)},
    '{2'd2, 3'd5, 16'hC333, 1'b0, 16'h0000},
    '{2'd0, 3'd5, 16'h0000, 1'b0, 16'h0000},
    '{2'd3, 3'd5, 16'h0000, 1'b1, initVal(5, 0, 4)},
    '{2'd3, 3'd5, 16'h0000, 1'b1, 16'hC333}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseCmd(input logic [1:0] op, input logic [2:0] mem, input logic [15:0] data);
    @(negedge clk);
    cmdOp = op; cmdMem = mem; hostData = data; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitDone();
    int guard = 0;
    busyCyc = 0;
    while (!done && guard < 20000) begin
      if (busy) busyCyc++;
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] mem, input logic [15:0] data);
    pulseCmd(op, mem, data);
    waitDone();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!busy && !done && !memWe && memSel == 6'd0, "R1 idle outputs",
          {busy, done, memWe, memSel}, 0);
    check(memAddr == 10'd0 && memSeg == 3'd4, "R1 pointer home", {memAddr, memSeg}, 4);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      w0 = weCount;
      issue(VECS[i].op, VECS[i].mem, VECS[i].data);
      if (VECS[i].op == 2'd2)
        check(weCount == w0 + 1, "R4 one write pulse per load", weCount - w0, 1);
      if (VECS[i].chk)
        check(dumpData == VECS[i].exp, "R2 R3 R5 table dump", dumpData, VECS[i].exp);
    end

    // R8 done lasts one cycle
    issue(2'd0, 3'd1, 16'h0);
    @(negedge clk);
    check(!done, "R8 done single cycle", done, 0);

    // R6 run to word 2; upper target bits ignored
    issue(2'd1, 3'd1, 16'hFC02);
    check(busyCyc == 11, "R6 R8 run cycles to word 2", busyCyc, 11);
    issue(2'd3, 3'd1, 16'h0);
    check(dumpData == initVal(1, 2, 4), "R6 pointer at word 2 seg 4", dumpData, initVal(1, 2, 4));

    // R3 run to last word and dump across the wrap
    issue(2'd1, 3'd1, 16'hFFFF);
    check(busyCyc == 5105, "R6 run cycles to word 1023", busyCyc, 5105);
    for (int s = 4; s >= 0; s--) begin
      issue(2'd3, 3'd1, 16'h0);
      check(dumpData == initVal(1, 1023, s), "R3 last word segments", dumpData, initVal(1, 1023, s));
    end
    issue(2'd3, 3'd1, 16'h0);
    check(dumpData == initVal(1, 0, 4), "R3 wrap to word 0", dumpData, initVal(1, 0, 4));

    // R6 run starting on target word realigns segment
    issue(2'd0, 3'd3, 16'h0);
    issue(2'd3, 3'd3, 16'h0);
    issue(2'd1, 3'd3, 16'h0400);
    check(busyCyc == 1, "R6 immediate hit", busyCyc, 1);
    issue(2'd3, 3'd3, 16'h0);
    check(dumpData == initVal(3, 0, 4), "R6 realigned to seg 4", dumpData, initVal(3, 0, 4));

    // R9 ignored while processors run
    procStopped = 1'b0;
    w0 = weCount;
    pulseCmd(2'd2, 3'd3, 16'h5A5A);
    repeat (3) @(negedge clk);
    check(!busy && weCount == w0, "R9 ignored while running", {busy, weCount - w0}, 0);
    procStopped = 1'b1;
    issue(2'd3, 3'd3, 16'h0);
    check(dumpData == initVal(3, 0, 3), "R9 pointer and data untouched", dumpData, initVal(3, 0, 3));

    // R9 ignored while busy
    issue(2'd0, 3'd4, 16'h0);
    w0 = weCount;
    pulseCmd(2'd1, 3'd4, 16'h0001);
    cmdOp = 2'd2; cmdMem = 3'd0; hostData = 16'hEEEE; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    waitDone();
    check(weCount == w0, "R9 no write while busy", weCount - w0, 0);
    issue(2'd3, 3'd0, 16'h0);
    check(dumpData == initVal(0, 0, 4), "R9 store 0 unchanged", dumpData, initVal(0, 0, 4));

    // R7 out-of-range store index ignored
    w0 = weCount;
    pulseCmd(2'd2, 3'd6, 16'h1234);
    repeat (3) @(negedge clk);
    check(!busy && weCount == w0, "R7 index 6 ignored", {busy, weCount - w0}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule